// File: doc/BRIEF.md
# Runtime-Configurable Serial Transmitter

This block turns bytes into asynchronous serial frames on one output line. A 31-bit setup word, which may be rewritten at any time, sets the frame shape and the bit rate. Its low 24 bits give the number of clocks per bit. Above that sit the data length, the stop length, parity enable, and a choice between parity computed from the data or parity held at a fixed level.

Bytes arrive over a valid/ready handshake. The block accepts a byte only while the line is idle. It then sends a low start bit, the data bits least significant first, the optional parity bit and one or two high stop bits. The setup word is captured when a byte is accepted, so software can prepare the next format while the current frame is still going out.

Top module: `cfg_uart_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1 and `in_ready` is 1.
- R2: A frame starts with one 0 bit, followed by the data bits least significant first. The data length comes from setup bits [29:28]: 00 gives 8 bits, 01 gives 7, 10 gives 6 and 11 gives 5. Unused high data bits are not sent.
- R3: Setup bit [27] = 1 sends two stop bits at level 1. With [27] = 0 one stop bit is sent.
- R4: With setup bit [26] = 1 and bit [25] = 0, a parity bit follows the data. When bit [24] = 1 it makes the count of ones in data plus parity even; when bit [24] = 0 it makes that count odd. With bit [26] = 0 no parity bit is sent.
- R5: With setup bits [26] = 1 and [25] = 1, the parity bit equals setup bit [24], whatever the data.
- R6: Every bit is held for exactly setup[23:0] clocks. A value of 0 is treated as 1.
- R7: The setup word and data byte are sampled in the accepting cycle. Changes to either during a frame do not alter that frame.
- R8: `in_ready` is 0 from the accepting clock edge until the last stop bit has ended. A valid byte offered in that window is not taken and produces no frame.
- R9: Setup bit [30] has no effect on the line.
- R10: A synchronous reset during a frame returns `tx_line` to 1 and `in_ready` to 1 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| setup_word | input | 31 | Frame format and clocks per bit |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Block can take a byte |
| tx_line | output | 1 | Serial output, idle high |

## Verification
The line falls to the start level one clock edge after the byte is accepted. Each bit then lasts exactly the programmed number of clocks. `in_ready` returns exactly frame-bits × period clocks after acceptance. The monitor therefore anchors on the first low sample and compares every sampled cycle of every bit against the queued frame. It checks `in_ready` low throughout the frame and high on the cycle just after the frame ends. Reset takes effect one edge after it is asserted. The bench samples on the falling clock edge and checks the line and ready at that first sample.

// File: rtl/uartx_pkg.sv
package uartx_pkg;
    localparam int SETUP_W  = 31;
    localparam int DIV_W    = 24;
    localparam int MAX_DATA = 8;
    localparam int IDX_W    = $clog2(MAX_DATA);

    typedef struct packed {
        logic [3:0]       data_bits;
        logic             two_stop;
        logic             par_en;
        logic             par_fixed;
        logic             par_sel;
        logic [DIV_W-1:0] period;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP
    } tx_state_e;

    function automatic frame_cfg_t decode_setup(input logic [SETUP_W-1:0] w);
        frame_cfg_t c;
        c.data_bits = 4'd8 - {2'b00, w[29:28]};
        c.two_stop  = w[27];
        c.par_en    = w[26];
        c.par_fixed = w[25];
        c.par_sel   = w[24];
        c.period    = w[DIV_W-1:0];
        return c;
    endfunction

    function automatic logic parity_bit(input frame_cfg_t c, input logic [MAX_DATA-1:0] d);
        logic x;
        x = 1'b0;
        for (int i = 0; i < MAX_DATA; i++)
            if (i < int'(c.data_bits)) x = x ^ d[i];
        if (c.par_fixed) return c.par_sel;
        return c.par_sel ? x : ~x;
    endfunction
endpackage

// File: rtl/uartx_setup_decode.sv
module uartx_setup_decode
    import uartx_pkg::*;
(
    input  logic [SETUP_W-1:0] setup_word,
    output frame_cfg_t         cfg
);
    logic unused_flow_flag;
    assign unused_flow_flag = setup_word[30];
    assign cfg = decode_setup(setup_word);
endmodule

// File: rtl/uartx_baud_timer.sv
module uartx_baud_timer
    import uartx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] load_period,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff;

    assign eff  = (load_period == '0) ? DIV_W'(1) : load_period;
    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (load)     cnt <= eff - DIV_W'(1);
        else if (cnt != 0) cnt <= cnt - DIV_W'(1);
    end

    assert_long_period_no_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (load && load_period > DIV_W'(1)) |=> !tick);
endmodule

// File: rtl/uartx_frame_seq.sv
module uartx_frame_seq
    import uartx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  frame_cfg_t          cfg_in,
    input  logic                in_valid,
    input  logic [MAX_DATA-1:0] in_data,
    output logic                in_ready,
    input  logic                tick,
    output logic                load,
    output logic [DIV_W-1:0]    load_period,
    output logic                tx_line
);
    tx_state_e           state;
    frame_cfg_t          cfg_q;
    logic [MAX_DATA-1:0] sh;
    logic [IDX_W-1:0]    idx;
    logic                par_q;
    logic                tx_q;
    logic                accept;
    logic [3:0]          last_idx;

    assign in_ready    = (state == ST_IDLE);
    assign accept      = in_ready && in_valid;
    assign load        = accept || (state != ST_IDLE && tick);
    assign load_period = accept ? cfg_in.period : cfg_q.period;
    assign last_idx    = cfg_q.data_bits - 4'd1;
    assign tx_line     = tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg_q <= '0;
            sh    <= '0;
            idx   <= '0;
            par_q <= 1'b0;
            tx_q  <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    cfg_q <= cfg_in;
                    sh    <= in_data;
                    par_q <= parity_bit(cfg_in, in_data);
                    tx_q  <= 1'b0;
                    state <= ST_START;
                end
                ST_START: if (tick) begin
                    idx   <= '0;
                    tx_q  <= sh[0];
                    sh    <= sh >> 1;
                    state <= ST_DATA;
                end
                ST_DATA: if (tick) begin
                    if ({1'b0, idx} == last_idx) begin
                        idx <= '0;
                        if (cfg_q.par_en) begin
                            tx_q  <= par_q;
                            state <= ST_PARITY;
                        end else begin
                            tx_q  <= 1'b1;
                            state <= ST_STOP;
                        end
                    end else begin
                        idx  <= idx + IDX_W'(1);
                        tx_q <= sh[0];
                        sh   <= sh >> 1;
                    end
                end
                ST_PARITY: if (tick) begin
                    tx_q  <= 1'b1;
                    idx   <= '0;
                    state <= ST_STOP;
                end
                ST_STOP: if (tick) begin
                    if (cfg_q.two_stop && idx == '0) idx <= IDX_W'(1);
                    else                             state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !tx_line);
    assert_data_idx_range_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> ({1'b0, idx} < cfg_q.data_bits));
    assert_bit_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && !tick) |=> $stable(tx_line));
    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(cfg_q));
endmodule

// File: rtl/cfg_uart_tx.sv
module cfg_uart_tx
    import uartx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SETUP_W-1:0] setup_word,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    output logic               tx_line
);
    frame_cfg_t       cfg;
    logic             tick;
    logic             load;
    logic [DIV_W-1:0] load_period;

    uartx_setup_decode u_dec (
        .setup_word (setup_word),
        .cfg        (cfg)
    );

    uartx_baud_timer u_tmr (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .load_period (load_period),
        .tick        (tick)
    );

    uartx_frame_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .cfg_in      (cfg),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .tick        (tick),
        .load        (load),
        .load_period (load_period),
        .tx_line     (tx_line)
    );

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> tx_line);
    assert_ready_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(in_ready) |-> $past(in_valid));
endmodule

// File: tb/cfg_uart_tx_tb.sv
module cfg_uart_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [30:0] setup_word = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        tx_line;

    int checks = 0;
    int fails  = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] bits;
        int          n;
        int          per;
        string       tag;
    } frame_t;

    frame_t exp_q[$];

    cfg_uart_tx u_dut (
        .clk        (clk),
        .rst        (rst),
        .setup_word (setup_word),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .tx_line    (tx_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic frame_t build(input logic [30:0] s, input logic [7:0] d, input string tag);
        frame_t f;
        int nd;
        logic x;
        nd     = 8 - int'(s[29:28]);
        f.bits = '0;
        f.n    = 1;
        x      = 1'b0;
        for (int i = 0; i < nd; i++) begin
            f.bits[f.n] = d[i];
            x = x ^ d[i];
            f.n++;
        end
        if (s[26]) begin
            f.bits[f.n] = s[25] ? s[24] : (s[24] ? x : ~x);
            f.n++;
        end
        for (int i = 0; i < (s[27] ? 2 : 1); i++) begin
            f.bits[f.n] = 1'b1;
            f.n++;
        end
        f.per = (s[23:0] == 0) ? 1 : int'(s[23:0]);
        f.tag = tag;
        return f;
    endfunction

    // Driver: pushes expected frame, offers byte, then scrambles inputs (R7)
    task automatic send(input logic [30:0] s, input logic [7:0] d, input string tag,
                        input bit push, input bit poke);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        if (push) exp_q.push_back(build(s, d, tag));
        setup_word = s;
        in_data    = d;
        in_valid   = 1'b1;
        @(negedge clk);
        in_valid   = 1'b0;
        setup_word = s ^ 31'h3F00_00F3;
        in_data    = ~d;
        if (poke) begin
            repeat (3) @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'h00;
            repeat (2) @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops expected frames and compares every sampled cycle
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && !tx_line) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected frame", 0, 1);
                end else begin
                    frame_t e;
                    int bad;
                    int rbad;
                    e    = exp_q.pop_front();
                    bad  = 0;
                    rbad = 0;
                    for (int i = 0; i < e.n; i++) begin
                        for (int c = 0; c < e.per; c++) begin
                            if (!(i == 0 && c == 0)) @(negedge clk);
                            if (tx_line !== e.bits[i]) bad++;
                            if (in_ready !== 1'b0) rbad++;
                        end
                    end
                    @(negedge clk);
                    check(bad == 0, e.tag, bad, 0);
                    check(rbad == 0 && in_ready === 1'b1 && tx_line === 1'b1,
                          "R8 ready low during frame, high after", rbad, 0);
                end
            end
        end
    end

    initial begin
        for (int k = 0; k < WATCHDOG; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(tx_line === 1'b1 && in_ready === 1'b1, "R1 line and ready in reset", tx_line, 1);
        rst = 1'b0;
        @(negedge clk);
        check(tx_line === 1'b1 && in_ready === 1'b1, "R1 idle after reset", tx_line, 1);
        mon_en = 1'b1;

        send({1'b0, 2'b00, 4'b0000, 24'd4}, 8'hA5, "R2 8 bits", 1, 0);
        send({1'b0, 2'b01, 4'b0000, 24'd3}, 8'hD3, "R2 7 bits", 1, 0);
        send({1'b0, 2'b10, 4'b0000, 24'd3}, 8'hED, "R2 6 bits", 1, 0);
        send({1'b0, 2'b11, 4'b0000, 24'd2}, 8'hF6, "R2 5 bits", 1, 0);
        send({1'b0, 2'b00, 4'b1000, 24'd3}, 8'h3C, "R3 two stop", 1, 0);
        send({1'b0, 2'b00, 4'b0101, 24'd3}, 8'h07, "R4 even parity", 1, 0);
        send({1'b0, 2'b00, 4'b0100, 24'd3}, 8'h07, "R4 odd parity", 1, 0);
        send({1'b0, 2'b01, 4'b1100, 24'd2}, 8'h80, "R4 odd parity 7 bits", 1, 0);
        send({1'b0, 2'b00, 4'b0111, 24'd2}, 8'h00, "R5 mark parity", 1, 0);
        send({1'b0, 2'b00, 4'b0110, 24'd2}, 8'hFF, "R5 space parity", 1, 0);
        send({1'b0, 2'b00, 4'b0000, 24'd1}, 8'h5A, "R6 period 1", 1, 0);
        send({1'b0, 2'b00, 4'b0000, 24'd0}, 8'h96, "R6 period 0 as 1", 1, 0);
        send({1'b0, 2'b00, 4'b1101, 24'd7}, 8'hC1, "R6 period 7", 1, 0);
        send({1'b1, 2'b00, 4'b0000, 24'd3}, 8'h69, "R9 flow flag ignored", 1, 0);
        send({1'b0, 2'b00, 4'b1000, 24'd5}, 8'h42, "R8 busy offer ignored", 1, 1);
        send({1'b0, 2'b10, 4'b0101, 24'd4}, 8'h2B, "R7 setup change mid-frame", 1, 0);

        @(negedge clk);
        while (exp_q.size() != 0 || !in_ready) @(negedge clk);
        repeat (5) @(negedge clk);

        mon_en = 1'b0;
        send({1'b0, 2'b00, 4'b0000, 24'd6}, 8'h00, "R10", 0, 0);
        repeat (9) @(negedge clk);
        check(tx_line === 1'b0, "R10 frame in progress before reset", tx_line, 0);
        rst = 1'b1;
        @(negedge clk);
        check(tx_line === 1'b1 && in_ready === 1'b1, "R10 idle one edge after reset", tx_line, 1);
        rst = 1'b0;
        begin
            int lows;
            lows = 0;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (tx_line !== 1'b1) lows++;
            end
            check(lows == 0, "R10 line stays idle after reset", lows, 0);
        end
        mon_en = 1'b1;
        send({1'b0, 2'b00, 4'b0000, 24'd2}, 8'h81, "R10 frame after reset", 1, 0);

        @(negedge clk);
        while (exp_q.size() != 0 || !in_ready) @(negedge clk);
        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule